// File: doc/BRIEF.md
# Forty-Bit Multiply-Accumulate Unit

This block is a single-cycle multiplier-accumulator for 16-bit operands. On every clock edge where the strobe is high it forms the product of the X and Y operands and either loads that product into a 40-bit accumulator, adds it to the accumulator, or subtracts it. Each operand carries its own signed/unsigned flag, so signed×signed, unsigned×unsigned and both mixed forms are available. The product needs at most 32 bits. The eight bits above it are guard bits, so long sums of products can grow past the 32-bit range without losing information.

Two further commands act on the accumulator alone. One clears it. The other clamps it to the largest positive or most negative 32-bit value when the guard bits show overflow. The full accumulator and an overflow flag are driven continuously from the accumulator register. A result therefore appears on the outputs one clock edge after its command is sampled.

Top module: `mac40_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator reads zero and the overflow flag is low.
- R2: Command code 000 (load) replaces the accumulator with the product, sign-extended from the product's natural width to 40 bits.
- R3: Command code 001 (accumulate) adds the sign-extended product to the accumulator.
- R4: Command code 010 (deduct) subtracts the sign-extended product from the accumulator.
- R5: Each operand is read as two's complement when its signed flag is 1 and as an unsigned integer when the flag is 0. All four combinations are supported.
- R6: Command code 011 (clear) sets the accumulator to zero.
- R7: With the strobe low, or with a command code of 101, 110 or 111, the accumulator keeps its value.
- R8: The overflow flag is high exactly when accumulator bits 39 down to 31 are not all equal.
- R9: Command code 100 (clamp) applies only when the overflow flag is set. It loads 0x007FFFFFFF when bit 39 is 0 and 0xFF80000000 when bit 39 is 1. With the flag clear it leaves the accumulator unchanged.
- R10: Accumulation and deduction wrap modulo 2^40.
- R11: Every command takes effect at the clock edge that samples it, and its result is on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Command strobe |
| op_i | input | 3 | Command code |
| x_signed_i | input | 1 | 1: X operand is two's complement |
| y_signed_i | input | 1 | 1: Y operand is two's complement |
| x_i | input | 16 | X operand |
| y_i | input | 16 | Y operand |
| acc_o | output | 40 | Accumulator value |
| ovf_o | output | 1 | Guard-bit overflow flag |

## Verification
The hardest case to reach from the ports is a carry out of the top guard bit, which makes the accumulator wrap. Each product adds at most 2^30 in signed mode, so the stimulus adds the largest positive signed product 1024 times in a row. This passes through the 32-bit overflow region, reaches the most negative 40-bit value, and returns to zero. Clamping in both directions is reached the same way: the bench stacks a few large products with accumulate and with deduct until the guard bits diverge, then issues clamp.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [2:0] {
    MAC_OP_LOAD  = 3'b000,
    MAC_OP_ADD   = 3'b001,
    MAC_OP_SUB   = 3'b010,
    MAC_OP_CLEAR = 3'b011,
    MAC_OP_SAT   = 3'b100
  } mac_op_e;
endpackage

// File: rtl/mac40_rst_sync.sv
module mac40_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              x_signed_i,
  input  logic              y_signed_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int FULL_W = 2 * EXT_W;

  logic signed [EXT_W-1:0]  x_ext;
  logic signed [EXT_W-1:0]  y_ext;
  logic signed [FULL_W-1:0] full_prod;

  always_comb begin
    x_ext     = {x_signed_i & x_i[DATA_W-1], x_i};
    y_ext     = {y_signed_i & y_i[DATA_W-1], y_i};
    full_prod = x_ext * y_ext;
    prod_o    = {{(ACC_W-FULL_W){full_prod[FULL_W-1]}}, full_prod};
  end
endmodule

// File: rtl/mac40_guard.sv
module mac40_guard #(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic             ovf_o,
  output logic [ACC_W-1:0] sat_val_o
);
  localparam int TOP_W = ACC_W - PROD_W + 1;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = acc_i[ACC_W-1:PROD_W-1];
    ovf_o    = !((&top_bits) || !(|top_bits));
    if (acc_i[ACC_W-1])
      sat_val_o = {{TOP_W{1'b1}}, {(PROD_W-1){1'b0}}};
    else
      sat_val_o = {{TOP_W{1'b0}}, {(PROD_W-1){1'b1}}};
  end
endmodule

// File: rtl/mac40_next.sv
module mac40_next
  import mac40_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [ACC_W-1:0] acc_q_i,
  input  logic [ACC_W-1:0] prod_i,
  input  logic             ovf_i,
  input  logic [ACC_W-1:0] sat_val_i,
  output logic [ACC_W-1:0] acc_d_o,
  output logic             acc_en_o
);
  always_comb begin
    acc_d_o  = acc_q_i;
    acc_en_o = 1'b0;
    if (valid_i) begin
      case (mac_op_e'(op_i))
        MAC_OP_LOAD: begin
          acc_d_o  = prod_i;
          acc_en_o = 1'b1;
        end
        MAC_OP_ADD: begin
          acc_d_o  = acc_q_i + prod_i;
          acc_en_o = 1'b1;
        end
        MAC_OP_SUB: begin
          acc_d_o  = acc_q_i - prod_i;
          acc_en_o = 1'b1;
        end
        MAC_OP_CLEAR: begin
          acc_d_o  = '0;
          acc_en_o = 1'b1;
        end
        MAC_OP_SAT: begin
          if (ovf_i) begin
            acc_d_o  = sat_val_i;
            acc_en_o = 1'b1;
          end
        end
        default: begin
          acc_en_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          valid_i,
  input  logic [2:0]                    op_i,
  input  logic                          x_signed_i,
  input  logic                          y_signed_i,
  input  logic [DATA_W-1:0]             x_i,
  input  logic [DATA_W-1:0]             y_i,
  output logic [2*DATA_W+GUARD_W-1:0]   acc_o,
  output logic                          ovf_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] sat_val;
  logic             ovf;

  mac40_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mac40_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .x_i        (x_i),
    .y_i        (y_i),
    .x_signed_i (x_signed_i),
    .y_signed_i (y_signed_i),
    .prod_o     (prod)
  );

  mac40_guard #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_guard (
    .acc_i     (acc_q),
    .ovf_o     (ovf),
    .sat_val_o (sat_val)
  );

  mac40_next #(.ACC_W(ACC_W)) u_next (
    .valid_i   (valid_i),
    .op_i      (op_i),
    .acc_q_i   (acc_q),
    .prod_i    (prod),
    .ovf_i     (ovf),
    .sat_val_i (sat_val),
    .acc_d_o   (acc_d),
    .acc_en_o  (acc_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  acc_q <= '0;
    else if (acc_en)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf;
endmodule

// File: rtl/mac40_unit_chk.sv
module mac40_unit_chk #(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic             x_signed_i,
  input logic             y_signed_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             ovf_o
);
  localparam int TOP_W = ACC_W - PROD_W + 1;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'b011) |=> (acc_o == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || op_i[2:1] == 2'b11 || op_i == 3'b101) |=> $stable(acc_o));

  // R8
  guard_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o == ($countones(acc_o[ACC_W-1:PROD_W-1]) != 0 &&
               $countones(acc_o[ACC_W-1:PROD_W-1]) != TOP_W)));

  // R9
  clamp_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'b100 && ovf_o) |=> !ovf_o);

  // R9
  clamp_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'b100 && !ovf_o) |=> $stable(acc_o));

  // R2
  unsigned_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'b000 && !x_signed_i && !y_signed_i)
      |=> (acc_o[ACC_W-1:PROD_W] == '0));
endmodule

bind mac40_unit mac40_unit_chk #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .x_signed_i (x_signed_i),
  .y_signed_i (y_signed_i),
  .acc_o      (acc_o),
  .ovf_o      (ovf_o)
);

// File: tb/mac40_unit_bench.sv
`timescale 1ns/1ps
module mac40_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'b000;
  logic        x_signed_i = 1'b0;
  logic        y_signed_i = 1'b0;
  logic [15:0] x_i = '0;
  logic [15:0] y_i = '0;
  logic [39:0] acc_o;
  logic        ovf_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [39:0] acc;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [39:0] model_acc = '0;

  always #2 clk = ~clk;

  mac40_unit u_mac40_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .x_signed_i(x_signed_i), .y_signed_i(y_signed_i),
    .x_i(x_i), .y_i(y_i), .acc_o(acc_o), .ovf_o(ovf_o)
  );

  function automatic logic guard_ovf(input logic [39:0] a);
    return !(a[39:31] == 9'h1FF || a[39:31] == 9'h000);
  endfunction

  task automatic check(input string tag, input logic [39:0] got_acc, input logic got_ovf,
                       input logic [39:0] want_acc, input logic want_ovf);
    checks++;
    if (got_acc !== want_acc || got_ovf !== want_ovf) begin
      failures++;
      $display("FAIL %s acc=%h ovf=%b expected acc=%h ovf=%b",
               tag, got_acc, got_ovf, want_acc, want_ovf);
    end
  endtask

  // Driver: applies one command and queues the expected outcome.
  task automatic drive(input string tag, input logic v, input logic [2:0] op,
                       input logic xs, input logic ys,
                       input logic [15:0] x, input logic [15:0] y);
    longint xv, yv, p;
    logic [39:0] p40;
    exp_t e;
    @(negedge clk);
    valid_i = v; op_i = op; x_signed_i = xs; y_signed_i = ys; x_i = x; y_i = y;
    xv = xs ? longint'($signed(x)) : longint'(x);
    yv = ys ? longint'($signed(y)) : longint'(y);
    p = xv * yv;
    p40 = p[39:0];
    if (v) begin
      case (op)
        3'b000: model_acc = p40;
        3'b001: model_acc = model_acc + p40;
        3'b010: model_acc = model_acc - p40;
        3'b011: model_acc = '0;
        3'b100: if (guard_ovf(model_acc))
                  model_acc = model_acc[39] ? 40'hFF80000000 : 40'h007FFFFFFF;
        default: ;
      endcase
    end
    e.acc = model_acc; e.ovf = guard_ovf(model_acc); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each result just after the edge that produced it (R11).
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, acc_o, ovf_o, e.acc, e.ovf);
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R1 in reset", acc_o, ovf_o, 40'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", acc_o, ovf_o, 40'h0, 1'b0);

    // R2 R5 load with each operand mode
    drive("R2 R5 ss load", 1, 3'b000, 1, 1, 16'd3, 16'hFFFC);
    drive("R2 R5 uu load", 1, 3'b000, 0, 0, 16'hFFFF, 16'hFFFF);
    drive("R2 R5 su load", 1, 3'b000, 1, 0, 16'hFFFF, 16'hFFFF);
    drive("R2 R5 us load", 1, 3'b000, 0, 1, 16'h8000, 16'h8000);
    // R3 R4
    drive("R3 accumulate", 1, 3'b001, 1, 1, 16'd1000, 16'd2000);
    drive("R4 deduct",     1, 3'b010, 1, 1, 16'h8001, 16'd7);
    // R7 idle and reserved codes
    drive("R7 strobe low", 0, 3'b011, 1, 1, 16'd5, 16'd5);
    drive("R7 code 101",   1, 3'b101, 1, 1, 16'd5, 16'd5);
    drive("R7 code 110",   1, 3'b110, 1, 1, 16'd5, 16'd5);
    drive("R7 code 111",   1, 3'b111, 1, 1, 16'd5, 16'd5);
    // R6
    drive("R6 clear", 1, 3'b011, 0, 0, 16'd9, 16'd9);
    // R8 R9 positive overflow then clamp
    drive("R8 add big",   1, 3'b001, 1, 1, 16'h8000, 16'h8000);
    drive("R8 overflow",  1, 3'b001, 1, 1, 16'h8000, 16'h8000);
    drive("R9 clamp pos", 1, 3'b100, 0, 0, 16'd0, 16'd0);
    drive("R9 clamp noop",1, 3'b100, 0, 0, 16'd0, 16'd0);
    // R9 negative clamp
    drive("R6 clear 2",   1, 3'b011, 0, 0, 16'd0, 16'd0);
    drive("R4 sub big",   1, 3'b010, 1, 1, 16'h8000, 16'h8000);
    drive("R4 sub big 2", 1, 3'b010, 1, 1, 16'h8000, 16'h8000);
    drive("R8 neg ovf",   1, 3'b010, 1, 1, 16'h8000, 16'h8000);
    drive("R9 clamp neg", 1, 3'b100, 1, 1, 16'd0, 16'd0);
    // R10 wrap through 2^40
    drive("R6 clear 3",   1, 3'b011, 0, 0, 16'd0, 16'd0);
    for (int i = 0; i < 1024; i++)
      drive("R10 wrap", 1, 3'b001, 1, 1, 16'h8000, 16'h8000);
    drive("R10 wrapped hold", 0, 3'b000, 0, 0, 16'd0, 16'd0);
    repeat (3) @(negedge clk);
    check("R10 final zero", acc_o, ovf_o, 40'h0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule